// File: doc/BRIEF.md
# Oversampled-to-Nyquist Decimation Chain

This block takes the multi-bit signed code of a cascaded (2-1-1) sigma-delta modulator at the oversampled rate and delivers high-resolution samples at 1/256 of that rate. The first section is a fifth-order cascaded integrator-comb filter that reduces the rate by 32. Its output is narrowed by dropping low bits and then passes through three identical half-band FIR stages. Each of these halves the rate again.

Each half-band stage uses the seven-tap kernel (-1, 0, 9, 16, 9, 0, -1)/32. Every product is built from shifts and adds in canonic signed digit form: 9x = 8x + x, 16x is a pure shift, and -x is a negation. The stage computes only on the samples it keeps. A source presents one sample per cycle with a strobe, and the chain raises its own strobe for one cycle whenever a final sample is ready.

Top module: `sdm_decim_chain`

## Requirements
- R1: After reset, `out_valid` pulses exactly once per 256 accepted inputs, with the first pulse on the 256th input. Inputs are counted only when `in_valid` is high.
- R2: A cycle with `in_valid` low has no effect on any later output, whatever the value on `in_data`.
- R3: The comb section has five integrators, accepted at the input rate, that wrap in two's complement at a width of IN_W+25 bits. They feed five combs with a differential delay of one, which run on every 32nd input. The comb result keeps its top MID_W bits (bits [IN_W+24:5]).
- R4: Each half-band stage forms (-t0 + 9*t2 + 16*t3 + 9*t4 - t6) arithmetically shifted right by 5. Here t0 is the newest of the last seven inputs. The stage emits on the 2nd, 4th, 6th ... input after reset.
- R5: A constant input d gives, once the filters have settled, the output d*2^20. The gain of each half-band stage at DC is exactly one.
- R6: The output sequence for any input stream is bit-exact against an integer model of R3 and R4. This includes the response to a single impulse.
- R7: During and right after reset, `out_valid` and `out_data` are 0.
- R8: `out_valid` is never high in two consecutive cycles, and `out_data` only changes together with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W (4) | Signed modulator code |
| out_valid | output | 1 | One-cycle strobe for a decimated sample |
| out_data | output | MID_W (24) | Signed decimated sample |

## Verification
The bench drives an impulse at full positive code, then a long constant run, then a pseudo-random code stream interleaved with idle cycles that carry garbage data. Every output is compared against an integer model.

- A decimation counter that advanced on idle cycles, or a phase error in any half-band stage, would shift or scramble the output sequence and change the pulse count.
- Integrators that saturated, or were too narrow, would break the constant-input value of 3*2^20 because the wrap would no longer cancel in the combs.
- A wrong canonic signed digit term, a logical instead of arithmetic shift, or a wrong truncation slice would break the impulse response and the negative samples of the random stream.

// File: rtl/sdm_decim_pkg.sv
package sdm_decim_pkg;
  // half-band kernel: (-1, 0, 9, 16, 9, 0, -1) / 2^HB_SHIFT
  localparam int HB_TAPS  = 7;
  localparam int HB_SHIFT = 5;
  // sum of |taps| is 36 < 2^6, so six guard bits hold any sum
  localparam int HB_GUARD = 6;
endpackage

// File: rtl/sdm_cic_decim.sv
module sdm_cic_decim #(
  parameter int IN_W  = 4,
  parameter int ORDER = 5,
  parameter int RATIO = 32,
  parameter int OUT_W = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);
  localparam int CTR_W = $clog2(RATIO);
  localparam int ACC_W = IN_W + ORDER * CTR_W;
  localparam logic [CTR_W-1:0] LAST = CTR_W'(RATIO - 1);

  logic signed [ACC_W-1:0] integ [ORDER];
  logic signed [ACC_W-1:0] cdly  [ORDER];
  logic signed [ACC_W-1:0] cstg  [ORDER+1];
  logic [CTR_W-1:0] phase;
  logic             dec_hit;

  assign dec_hit = in_valid && (phase == LAST);

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else if (in_valid) phase <= phase + 1'b1;
  end

  for (genvar k = 0; k < ORDER; k++) begin : g_int
    always_ff @(posedge clk) begin
      if (rst) integ[k] <= '0;
      else if (in_valid) begin
        if (k == 0) integ[k] <= integ[k] + {{(ACC_W-IN_W){in_data[IN_W-1]}}, in_data};
        else        integ[k] <= integ[k] + integ[k-1];
      end
    end
  end

  assign cstg[0] = integ[ORDER-1];
  for (genvar k = 0; k < ORDER; k++) begin : g_comb
    assign cstg[k+1] = cstg[k] - cdly[k];
    always_ff @(posedge clk) begin
      if (rst) cdly[k] <= '0;
      else if (dec_hit) cdly[k] <= cstg[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= dec_hit;
      if (dec_hit) out_data <= cstg[ORDER][ACC_W-1 -: OUT_W];
    end
  end

  AST_CIC_SPACED: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R1
  AST_INTEG_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(integ[0])); // R2
endmodule

// File: rtl/sdm_halfband.sv
module sdm_halfband #(
  parameter int W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_data,
  output logic                out_valid,
  output logic signed [W-1:0] out_data
);
  import sdm_decim_pkg::*;
  localparam int SW = W + HB_GUARD;

  logic signed [W-1:0]  hist [HB_TAPS-1];
  logic signed [W-1:0]  win  [HB_TAPS];
  logic signed [SW-1:0] ext  [HB_TAPS];
  logic signed [SW-1:0] acc;
  logic signed [SW-1:0] scaled;
  logic                 odd;

  assign win[0] = in_data;
  for (genvar i = 0; i < HB_TAPS; i++) begin : g_win
    if (i > 0) begin : g_old
      assign win[i] = hist[i-1];
    end
    assign ext[i] = {{HB_GUARD{win[i][W-1]}}, win[i]};
  end

  // canonic signed digit products: 9x = (x<<3)+x, 16x = x<<4
  assign acc = (ext[2] <<< 3) + ext[2] + (ext[4] <<< 3) + ext[4]
             + (ext[3] <<< 4) - ext[0] - ext[6];
  assign scaled = acc >>> HB_SHIFT;

  for (genvar i = 0; i < HB_TAPS-1; i++) begin : g_hist
    always_ff @(posedge clk) begin
      if (rst) hist[i] <= '0;
      else if (in_valid) hist[i] <= win[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      odd       <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid && odd;
      if (in_valid) begin
        odd <= ~odd;
        if (odd) out_data <= scaled[W-1:0];
      end
    end
  end

  AST_HB_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R4
  AST_HB_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data)); // R2
endmodule

// File: rtl/sdm_decim_chain.sv
module sdm_decim_chain #(
  parameter int IN_W      = 4,
  parameter int CIC_ORDER = 5,
  parameter int CIC_RATIO = 32,
  parameter int MID_W     = 24,
  parameter int HB_STAGES = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  output logic signed [MID_W-1:0] out_data
);
  logic                    sv [HB_STAGES+1];
  logic signed [MID_W-1:0] sd [HB_STAGES+1];

  sdm_cic_decim #(
    .IN_W(IN_W), .ORDER(CIC_ORDER), .RATIO(CIC_RATIO), .OUT_W(MID_W)
  ) u_cic (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(sv[0]), .out_data(sd[0])
  );

  for (genvar s = 0; s < HB_STAGES; s++) begin : g_hb
    sdm_halfband #(.W(MID_W)) u_hb (
      .clk(clk), .rst(rst), .in_valid(sv[s]), .in_data(sd[s]),
      .out_valid(sv[s+1]), .out_data(sd[s+1])
    );
  end

  assign out_valid = sv[HB_STAGES];
  assign out_data  = sd[HB_STAGES];

  AST_OUT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data)); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    $fell(rst) |-> (!out_valid && out_data == '0)); // R7
endmodule

// File: tb/sdm_decim_chain_test.sv
module sdm_decim_chain_test;
  localparam int IN_W = 4;
  localparam int MW   = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [IN_W-1:0] in_data = '0;
  logic out_valid;
  logic signed [MW-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int n_in   = 0;
  int back2back = 0;
  bit prev_v = 1'b0;

  int got[$];
  int exp_q[$];
  string tag_q[$];
  string cur_tag = "R6";

  // behavioural model state
  logic signed [28:0] m_int [5];
  logic signed [28:0] m_dly [5];
  int m_cnt;
  int m_tap [3][7];
  int m_ph  [3];

  always #2.5 clk = ~clk;

  sdm_decim_chain uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 5; k++) begin m_int[k] = '0; m_dly[k] = '0; end
    m_cnt = 0;
    for (int s = 0; s < 3; s++) begin
      m_ph[s] = 0;
      for (int t = 0; t < 7; t++) m_tap[s][t] = 0;
    end
  endtask

  task automatic hb_push(input int s, input int v);
    int y;
    for (int t = 6; t > 0; t--) m_tap[s][t] = m_tap[s][t-1];
    m_tap[s][0] = v;
    if (m_ph[s] == 1) begin
      y = (-m_tap[s][0] + 9*m_tap[s][2] + 16*m_tap[s][3] + 9*m_tap[s][4] - m_tap[s][6]) >>> 5;
      if (s < 2) hb_push(s + 1, y);
      else begin exp_q.push_back(y); tag_q.push_back(cur_tag); end
    end
    m_ph[s] = 1 - m_ph[s];
  endtask

  // R3: modular integrators (old values), combs on every 32nd input
  task automatic model_push(input int x);
    logic signed [28:0] old [5];
    logic signed [28:0] v, t;
    for (int k = 0; k < 5; k++) old[k] = m_int[k];
    m_int[0] = old[0] + 29'(x);
    for (int k = 1; k < 5; k++) m_int[k] = old[k] + old[k-1];
    if (m_cnt == 31) begin
      v = old[4];
      for (int k = 0; k < 5; k++) begin
        t = v - m_dly[k];
        m_dly[k] = v;
        v = t;
      end
      hb_push(0, int'($signed(v[28:5])));
    end
    m_cnt = (m_cnt + 1) % 32;
  endtask

  task automatic put(input int x);
    in_data = IN_W'(x);
    in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    n_in++;
    model_push(x);
  endtask

  task automatic idle(input int junk);
    in_data = IN_W'(junk);
    in_valid = 1'b0;
    @(posedge clk); #1;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid && prev_v) back2back++;
      if (out_valid) got.push_back(int'(out_data));
      prev_v = out_valid;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    logic [15:0] lfsr;
    int dc_hits;
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R7 valid in reset", int'(out_valid), 0);
    check(out_data == '0, "R7 data in reset", int'(out_data), 0);
    #1; rst = 1'b0;
    @(posedge clk); #1;
    @(negedge clk);
    check(out_valid == 1'b0 && out_data == '0, "R7 after reset", int'(out_data), 0);
    @(posedge clk); #1;

    // impulse (R6)
    cur_tag = "R6";
    put(7);
    for (int i = 1; i < 256*16; i++) put(0);

    // constant run (R3 R5)
    cur_tag = "R3 R5";
    for (int i = 0; i < 256*20; i++) put(3);

    // random codes with idle garbage cycles (R2 R4)
    cur_tag = "R2 R4";
    lfsr = 16'hACE1;
    for (int i = 0; i < 256*10; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[2:0] == 3'd5) idle(int'(lfsr[7:4]));
      put(int'(lfsr[11:8]) % 9 - 4);
    end
    repeat (40) @(posedge clk);
    @(negedge clk);

    check(got.size() == n_in / 256, "R1 output count", got.size(), n_in / 256);
    check(exp_q.size() == n_in / 256, "R1 model count", exp_q.size(), n_in / 256);
    check(back2back == 0, "R8 consecutive valids", back2back, 0);
    for (int i = 0; i < exp_q.size(); i++) begin
      if (i < got.size()) check(got[i] == exp_q[i], {tag_q[i], " R6 sample"}, got[i], exp_q[i]);
      else check(1'b0, "R1 missing sample", 0, exp_q[i]);
    end
    // R5: settled constant output, independent of the model
    dc_hits = 0;
    for (int i = 32; i < 36; i++) begin
      if (i < got.size()) check(got[i] == 3 * (1 << 20), "R5 DC gain", got[i], 3 * (1 << 20));
      else check(1'b0, "R5 DC sample missing", 0, 3 * (1 << 20));
      dc_hits++;
    end
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end
endmodule